// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns an unpacked floating-point operand into a signed 32-bit two's-complement integer. The operand arrives as a class code, a sign, a signed unbiased exponent and a 64-bit normalized mantissa. The mantissa has an explicit leading one at its top bit, so the operand's value is `mant * 2^(exp - 63)`. The conversion always truncates toward zero and ignores any rounding mode. It raises an inexact flag when fraction bits are dropped. It raises an invalid flag when the operand cannot be represented.

Each operand is presented for one cycle with `inValid` high. The result and both flags are registered and appear one cycle later, together with a one-cycle `outValid` pulse. When `inValid` is low, the registered outputs hold their last value.

The overflow test is asymmetric because of the sign. A negative magnitude of exactly 2^31 converts to -2^31. A positive magnitude of 2^31 saturates. A saturated result never carries the inexact flag; the invalid flag takes its place.

Top module: `f2i_trunc`

## Requirements
- R1: After reset, `outValid`, `result`, `inexact` and `invalid` are all zero.
- R2: An operand accepted with `inValid` high produces its result, its flags and a one-cycle `outValid` pulse on the next clock edge. While `inValid` is low, `outValid` is low and `result`, `inexact` and `invalid` keep their previous values.
- R3: The class code is 3 bits: zero = 0, number = 1, infinity = 2, quiet NaN = 3, signaling NaN = 4. A zero-class operand of either sign yields result 0 with both flags clear, whatever its exponent and mantissa.
- R4: For a number-class operand with exponent 0 to 31, the magnitude m is the integer part `mant >> (63 - exp)`. When no overflow occurs, the result is m for sign 0 and the two's-complement negation of m for sign 1.
- R5: For a number-class operand that does not overflow, `inexact` is set exactly when a nonzero bit of the mantissa is discarded. A negative exponent gives result 0 with `inexact` set.
- R6: A number-class operand with exponent 32 or larger (exponent is 12-bit two's complement) overflows.
- R7: A number-class operand overflows when m >= 2^31 + sign. A negative operand of magnitude exactly 2^31 (even with fraction bits below it) converts to 0x80000000 without the invalid flag.
- R8: Infinity, quiet NaN, signaling NaN and the unused class codes 5 to 7 always take the overflow path.
- R9: On overflow, the result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1, with `invalid` set and `inexact` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand strobe, one conversion per high cycle |
| inClass | input | 3 | Operand class code |
| inSign | input | 1 | Operand sign, 1 = negative |
| inExp | input | 12 | Unbiased exponent, two's complement |
| inMant | input | 64 | Normalized mantissa, leading one at bit 63 |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| result | output | 32 | Signed integer result |
| inexact | output | 1 | Fraction bits were discarded |
| invalid | output | 1 | Operand was out of range or not a number |

## Verification
The hardest case to reach is the narrow band at exponent 31, where the sign alone decides between a valid -2^31 and saturation. The stimulus sweeps every exponent from -3 to 40 with both signs and several mantissa patterns. These include a lone leading one, a mantissa with its integer part at 0x80000001, and a mantissa with a fraction below 2^31. The sweep therefore lands on both sides of that boundary and of the inexact boundary. Exponents far out of range and the non-number classes are then driven with mantissas that would otherwise give valid results.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam logic [2:0] CLS_ZERO = 3'd0;
  localparam logic [2:0] CLS_NUM  = 3'd1;
  localparam logic [2:0] CLS_INF  = 3'd2;
  localparam logic [2:0] CLS_QNAN = 3'd3;
  localparam logic [2:0] CLS_SNAN = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new result
    logic zeroPath;  // force a clean zero
    logic satPath;   // class or exponent forces saturation
    logic fracOnly;  // exponent below zero: pure fraction
  } f2i_strb_t;
endpackage

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
  import f2i_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int EXP_W = 12
) (
  input  logic                    inValid,
  input  logic [2:0]              inClass,
  input  logic signed [EXP_W-1:0] inExp,
  output f2i_strb_t               strb
);
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

  logic isNum, isZero, bigExp;

  always_comb begin
    isZero        = (inClass == CLS_ZERO);
    isNum         = (inClass == CLS_NUM);
    bigExp        = (inExp >= EXP_LIM);
    strb.load     = inValid;
    strb.zeroPath = isZero;
    strb.satPath  = (!isZero && !isNum) || (isNum && bigExp);
    strb.fracOnly = isNum && inExp[EXP_W-1];
  end
endmodule

// File: rtl/f2i_dpath.sv
module f2i_dpath
  import f2i_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 12,
  parameter int MANT_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  f2i_strb_t               strb,
  input  logic                    inSign,
  input  logic signed [EXP_W-1:0] inExp,
  input  logic [MANT_W-1:0]       inMant,
  output logic                    outValid,
  output logic [INT_W-1:0]        resQ,
  output logic                    inexQ,
  output logic                    invQ
);
  localparam int IDX_W = $clog2(INT_W);
  localparam int SH_W  = $clog2(MANT_W) + 1;
  localparam logic [INT_W:0]   HALF    = (INT_W+1)'(1) << (INT_W - 1);
  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

  logic [IDX_W-1:0]  expIdx;
  logic [SH_W-1:0]   shAmt;
  logic [MANT_W-1:0] shifted, lostMask;
  logic [INT_W-1:0]  mag, signedVal, satVal;
  logic              lostBits, rangeOvf;

  always_comb begin
    expIdx   = inExp[IDX_W-1:0];
    shAmt    = SH_W'(MANT_W - 1) - SH_W'(expIdx);
    shifted  = inMant >> shAmt;
    lostMask = ~({MANT_W{1'b1}} << shAmt);
    if (strb.fracOnly) begin
      mag      = '0;
      lostBits = |inMant;
    end else begin
      mag      = shifted[INT_W-1:0];
      lostBits = |(inMant & lostMask);
    end
    rangeOvf  = ({1'b0, mag} >= (HALF + (INT_W+1)'(inSign)));
    signedVal = inSign ? (~mag + INT_W'(1)) : mag;
    satVal    = inSign ? NEG_SAT : POS_SAT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      resQ     <= '0;
      inexQ    <= 1'b0;
      invQ     <= 1'b0;
    end else begin
      outValid <= strb.load;
      if (strb.load) begin
        if (strb.zeroPath) begin
          resQ  <= '0;
          inexQ <= 1'b0;
          invQ  <= 1'b0;
        end else if (strb.satPath || rangeOvf) begin
          resQ  <= satVal;
          inexQ <= 1'b0;
          invQ  <= 1'b1;
        end else begin
          resQ  <= signedVal;
          inexQ <= lostBits;
          invQ  <= 1'b0;
        end
      end
    end
  end

  // R2
  load_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> outValid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> (!outValid && $stable(resQ) && $stable(inexQ) && $stable(invQ)));
  // R3
  zero_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.zeroPath) |=> (resQ == '0 && !inexQ && !invQ));
  // R5
  frac_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.fracOnly) |=> (resQ == '0 && inexQ && !invQ));
  // R9
  sat_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && invQ) |-> (!inexQ && (resQ == (resQ[INT_W-1] ? NEG_SAT : POS_SAT))));
endmodule

// File: rtl/f2i_trunc.sv
module f2i_trunc
  import f2i_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 12,
  parameter int MANT_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [2:0]              inClass,
  input  logic                    inSign,
  input  logic signed [EXP_W-1:0] inExp,
  input  logic [MANT_W-1:0]       inMant,
  output logic                    outValid,
  output logic [INT_W-1:0]        result,
  output logic                    inexact,
  output logic                    invalid
);
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

  f2i_strb_t strb;

  f2i_ctrl #(.INT_W(INT_W), .EXP_W(EXP_W)) u_ctrl (
    .inValid (inValid),
    .inClass (inClass),
    .inExp   (inExp),
    .strb    (strb)
  );

  f2i_dpath #(.INT_W(INT_W), .EXP_W(EXP_W), .MANT_W(MANT_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inSign   (inSign),
    .inExp    (inExp),
    .inMant   (inMant),
    .outValid (outValid),
    .resQ     (result),
    .inexQ    (inexact),
    .invQ     (invalid)
  );

  // R6
  big_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inClass == CLS_NUM && inExp >= EXP_LIM) |=> (invalid && !inexact));
  // R8
  non_number_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inClass != CLS_NUM && inClass != CLS_ZERO) |=> invalid);
endmodule

// File: tb/tb_f2i_trunc.sv
module tb_f2i_trunc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  inClass = 3'd0;
  logic        inSign = 1'b0;
  logic signed [11:0] inExp = '0;
  logic [63:0] inMant = '0;
  logic        outValid, inexact, invalid;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  f2i_trunc dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass),
    .inSign(inSign), .inExp(inExp), .inMant(inMant),
    .outValid(outValid), .result(result), .inexact(inexact), .invalid(invalid)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic conv(input logic [2:0] c, input logic s, input int e, input logic [63:0] m);
    logic [31:0] eRes;
    logic        eInx, eInv;
    logic [63:0] mag64;
    int          sh;
    string       tag;
    if (c == 3'd0) begin
      eRes = 0; eInx = 0; eInv = 0; tag = "R3";
    end else if (c != 3'd1) begin
      eRes = s ? 32'h8000_0000 : 32'h7FFF_FFFF; eInx = 0; eInv = 1; tag = "R8/R9";
    end else if (e >= 32) begin
      eRes = s ? 32'h8000_0000 : 32'h7FFF_FFFF; eInx = 0; eInv = 1; tag = "R6/R9";
    end else if (e < 0) begin
      eRes = 0; eInx = (m != 0); eInv = 0; tag = "R5";
    end else begin
      sh    = 63 - e;
      mag64 = m >> sh;
      if (mag64 >= (64'h8000_0000 + 64'(s))) begin
        eRes = s ? 32'h8000_0000 : 32'h7FFF_FFFF; eInx = 0; eInv = 1; tag = "R7/R9";
      end else begin
        eRes = s ? 32'(-mag64) : mag64[31:0];
        eInx = ((mag64 << sh) != m);
        eInv = 0;
        tag  = "R4/R5";
      end
    end
    @(negedge clk);
    inValid = 1'b1; inClass = c; inSign = s; inExp = 12'(e); inMant = m;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b1, "R2 outValid", 64'(outValid), 64'd1);
    chk(result == eRes, {tag, " result"}, 64'(result), 64'(eRes));
    chk(inexact == eInx && invalid == eInv, {tag, " flags"},
        64'({inexact, invalid}), 64'({eInx, eInv}));
  endtask

  initial begin
    logic [63:0] pats [5];
    logic [31:0] holdRes;
    logic        holdInx, holdInv;
    logic [63:0] lfsr;
    pats[0] = 64'h8000_0000_0000_0000;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'hC000_0000_8000_0000;
    pats[3] = 64'h8000_0001_0000_0000;
    pats[4] = 64'h8000_0000_4000_0000;

    repeat (3) @(negedge clk);
    // R1: reset values
    chk(outValid == 0 && result == 0 && inexact == 0 && invalid == 0, "R1 reset",
        64'({outValid, inexact, invalid, result}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 R5 R6 R7: exponent sweep
    for (int e = -3; e <= 40; e++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 5; p++)
          conv(3'd1, s[0], e, pats[p]);

    lfsr = 64'hACE1_2345_6789_BEEF;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      conv(3'd1, lfsr[5], (i % 36) - 2, {1'b1, lfsr[62:0]});
    end

    // R7: exact -2^31 passes, +2^31 saturates
    conv(3'd1, 1'b1, 31, 64'h8000_0000_0000_0000);
    conv(3'd1, 1'b0, 31, 64'h8000_0000_0000_0000);

    // R6: far out-of-range exponents
    conv(3'd1, 1'b0, 2047, 64'h8000_0000_0000_0000);
    conv(3'd1, 1'b1, 1000, 64'hFFFF_0000_0000_0000);
    conv(3'd1, 1'b1, -2048, 64'h8000_0000_0000_0000);

    // R3 and R8: classes, with operand fields that would otherwise convert
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 2; s++)
        if (c != 1) conv(3'(c), s[0], 5, 64'hC000_0000_0000_0001);

    // R2: idle inputs are ignored and outputs hold
    conv(3'd1, 1'b1, 3, 64'hA000_0000_0000_0000);
    holdRes = result; holdInx = inexact; holdInv = invalid;
    inClass = 3'd2; inSign = 1'b0; inExp = 12'sd40; inMant = '1;
    @(negedge clk);
    chk(outValid == 0, "R2 idle outValid", 64'(outValid), 64'd0);
    chk(result == holdRes && inexact == holdInx && invalid == holdInv, "R2 idle hold",
        64'({inexact, invalid, result}), 64'({holdInx, holdInv, holdRes}));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule